// File: doc/BRIEF.md
# Probabilistic Bit Network Update Engine

The engine holds a small, fully connected network of N stochastic binary units. A host loads a signed weight for every ordered pair of units and a signed bias for each unit. It then raises a run control. From that point the engine updates the units one after another and in a fixed loop. For the unit being updated it builds a local field. The field is the bias plus the weighted contribution of every other unit's present state, where each unit counts as +1 or -1. The engine clamps that field and compares it with a pseudo-random number. The result of the comparison becomes the unit's new state, and the next unit then uses it.

When a full pass over all N units is complete, the engine presents the N-bit state vector to the host on a valid/ready sample port. It waits there until the host takes the vector. Dropping the run control freezes the engine wherever it is. Parameter writes are only accepted while the engine is frozen, so the host cannot change weights while the network is sampling.

Top module: `pbit_net`

## Requirements
- R1: After reset the state vector is all zeros, `smp_valid` is low, and all weights and biases are zero.
- R2: A write is stored only in a cycle where `wr_en` is high and `run` is low. `wr_bias`=1 stores `wr_data` as the bias of unit `wr_row`. `wr_bias`=0 stores it as the weight from unit `wr_col` into unit `wr_row`. A write presented while `run` is high has no effect.
- R3: The field of unit i is the bias of i, plus the weight (i,j) for every other unit j whose state is 1, minus the weight (i,j) for every other unit j whose state is 0. Weight (i,i) never contributes.
- R4: The field is clamped to the signed range of FW bits, from -2^(FW-1) to 2^(FW-1)-1, before the comparison. A field beyond that range never wraps.
- R5: The new state of a unit is 1 exactly when the clamped field is greater than r. Here r is the low FW bits, read as signed, of a 16-bit shift register. The register shifts left once per unit decision and takes in bit15^bit13^bit12^bit10. It starts at SEED.
- R6: Units are updated in index order 0..N-1. Each update takes N+1 enabled cycles: N accumulate cycles, then one decision cycle. Each update sees the newest states of all other units.
- R7: In the cycle after unit N-1 is decided, `smp_valid` rises and `smp_data` carries the state vector. Both stay unchanged until the host accepts.
- R8: While `smp_valid` is high the engine makes no progress. A clock edge with `smp_valid` and `smp_ready` both high clears `smp_valid`, and the next sweep starts at unit 0 on the following edge.
- R9: While `run` is low the engine holds its position, its state vector and its random register, even in the middle of a sweep. It resumes from the same place when `run` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine enable; parameter writes need it low |
| wr_en | input | 1 | Parameter write strobe |
| wr_bias | input | 1 | 1 = bias write, 0 = weight write |
| wr_row | input | $clog2(N) | Unit whose field the value feeds |
| wr_col | input | $clog2(N) | Source unit of a weight |
| wr_data | input | WW | Signed weight or bias |
| smp_valid | output | 1 | Completed sweep available |
| smp_ready | input | 1 | Host accepts the sample |
| smp_data | output | N | Present state vector |

## Verification
The bench drives large biases and weights so that the unclamped field would wrap in FW bits. A design that wraps instead of clamping produces ones where the clamped field forces zeros, and zeros where it forces ones. It loads non-zero self-weights and writes while running. A design that adds the diagonal term or accepts live writes drifts away from the reference vectors. The bench also stalls the sample port for many cycles and freezes the engine in the middle of a sweep. A design that keeps advancing its position or random register during either one shows a changed vector or a misplaced `smp_valid` edge on the clock-by-clock comparison.

// File: rtl/pbit_net.sv
module pbit_net #(
  parameter int N = 8,
  parameter int WW = 8,
  parameter int FW = 12,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 wr_en,
  input  logic                 wr_bias,
  input  logic [$clog2(N)-1:0] wr_row,
  input  logic [$clog2(N)-1:0] wr_col,
  input  logic [WW-1:0]        wr_data,
  output logic                 smp_valid,
  input  logic                 smp_ready,
  output logic [N-1:0]         smp_data
);
  localparam int IW  = $clog2(N);
  localparam int CW  = $clog2(N + 1);
  localparam int XW  = $clog2(N * N);
  localparam int AW  = WW + $clog2(N + 1) + 1;
  localparam int SW  = (AW > FW) ? AW : FW;
  localparam logic signed [SW-1:0] FMAX = SW'((2 ** (FW - 1)) - 1);
  localparam logic signed [SW-1:0] FMIN = SW'(-(2 ** (FW - 1)));

  logic signed [WW-1:0] w [N*N];
  logic signed [WW-1:0] h [N];
  logic [N-1:0]         m;
  logic [IW-1:0]        bi;
  logic [CW-1:0]        ph;
  logic [IW-1:0]        jx;
  logic signed [AW-1:0] acc, acc_nx, term, wv, hv;
  logic signed [SW-1:0] ax;
  logic signed [FW-1:0] fld, rnd;
  logic [15:0]          lfsr;
  logic [XW-1:0]        widx, waddr;
  logic                 step, decide, bit_new;

  assign step    = run & ~smp_valid;
  assign decide  = step & (ph == CW'(N));
  assign jx      = IW'(ph);
  assign widx    = XW'(bi) * XW'(N) + XW'(jx);
  assign waddr   = XW'(wr_row) * XW'(N) + XW'(wr_col);
  assign wv      = AW'(w[widx]);
  assign hv      = AW'(h[bi]);
  assign term    = (jx == bi) ? '0 : (m[jx] ? wv : -wv);
  assign acc_nx  = (ph == '0) ? hv + term : acc + term;
  assign ax      = SW'(acc);
  assign fld     = (ax > FMAX) ? FW'(FMAX) : (ax < FMIN) ? FW'(FMIN) : FW'(ax);
  assign rnd     = lfsr[FW-1:0];
  assign bit_new = fld > rnd;
  assign smp_data = m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N * N; k++) w[k] <= '0;
      for (int k = 0; k < N; k++) h[k] <= '0;
    end else if (wr_en && !run && (32'(wr_row) < N) && (32'(wr_col) < N)) begin
      if (wr_bias) h[wr_row] <= wr_data;
      else         w[waddr]  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m         <= '0;
      bi        <= '0;
      ph        <= '0;
      acc       <= '0;
      lfsr      <= SEED;
      smp_valid <= 1'b0;
    end else if (smp_valid) begin
      if (smp_ready) smp_valid <= 1'b0;
    end else if (step) begin
      if (decide) begin
        m[bi] <= bit_new;
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ph    <= '0;
        if (bi == IW'(N - 1)) begin
          bi        <= '0;
          smp_valid <= 1'b1;
        end else begin
          bi <= bi + 1'b1;
        end
      end else begin
        acc <= acc_nx;
        ph  <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbit_net_chk.sv
module pbit_net_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         smp_valid,
  input logic         smp_ready,
  input logic [N-1:0] smp_data
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!smp_valid && smp_data == '0));

  p_one_bit_per_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(smp_data ^ $past(smp_data)) <= 1);

  p_sample_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

  p_sample_rise_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(run));

  p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_valid);

  p_halt_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(smp_data) && !$rose(smp_valid)));
endmodule

bind pbit_net pbit_net_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
);

// File: tb/pbit_net_test.sv
module pbit_net_test;
  localparam int N = 8;
  localparam int WW = 8;
  localparam int FW = 10;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, wr_en = 1'b0, wr_bias = 1'b0, smp_ready = 1'b0;
  logic [IW-1:0] wr_row = '0, wr_col = '0;
  logic [WW-1:0] wr_data = '0;
  logic smp_valid;
  logic [N-1:0] smp_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pbit_net #(.N(N), .WW(WW), .FW(FW), .SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_bias(wr_bias),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
  );

  // behavioural reference
  int mw [N*N];
  int mh [N];
  logic [N-1:0] mm;
  int mbi, mph;
  logic [15:0] ml;
  bit mval;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N*N; k++) mw[k] = 0;
      for (int k = 0; k < N; k++) mh[k] = 0;
      mm = '0; mbi = 0; mph = 0; ml = SEED; mval = 0;
    end else begin
      if (wr_en && !run) begin
        if (wr_bias) mh[wr_row] = int'($signed(wr_data));
        else mw[int'(wr_row)*N + int'(wr_col)] = int'($signed(wr_data));
      end
      if (mval) begin
        if (smp_ready) mval = 0;
      end else if (run) begin
        if (mph < N) mph++;
        else begin
          int f, r;
          f = mh[mbi];
          for (int j = 0; j < N; j++)
            if (j != mbi) f += mm[j] ? mw[mbi*N+j] : -mw[mbi*N+j];
          if (f > 2**(FW-1) - 1) f = 2**(FW-1) - 1;
          if (f < -(2**(FW-1))) f = -(2**(FW-1));
          r = int'(ml) % (2**FW);
          if (r >= 2**(FW-1)) r -= 2**FW;
          mm[mbi] = (f > r);
          ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
          mph = 0;
          if (mbi == N-1) begin mbi = 0; mval = 1; end
          else mbi++;
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if (smp_valid !== mval) begin
        fails++;
        $display("FAIL R7 smp_valid actual=%0b expected=%0b at %0t", smp_valid, mval, $time);
      end
      checks++;
      if (smp_data !== mm) begin
        fails++;
        $display("FAIL R3 R5 R6 smp_data actual=%b expected=%b at %0t", smp_data, mm, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input bit b, input int r, input int c, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_bias = b; wr_row = IW'(r); wr_col = IW'(c); wr_data = WW'(d);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sample(output logic [N-1:0] d);
    do @(negedge clk); while (!smp_valid);
    d = smp_data;
  endtask

  task automatic halt_at_boundary();
    logic [N-1:0] d;
    smp_ready = 1'b0;
    wait_sample(d);
    run = 1'b0;
    smp_ready = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [N-1:0] d, held;
    int seed;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", smp_data, '0);
    chk("R1 reset valid", {{(N-1){1'b0}}, smp_valid}, '0);

    // R4: huge negative field must clamp, never wrap
    for (int i = 0; i < N; i++) begin
      wr(1, i, 0, 127);
      for (int j = 0; j < N; j++) wr(0, i, j, 127);
    end
    wr_end();
    run = 1'b1; smp_ready = 1'b1;
    for (int s = 0; s < 3; s++) begin
      wait_sample(d);
      chk("R4 negative clamp sample", d, '0);
    end
    halt_at_boundary();

    // R4 and R3: positive saturation with a large self-weight that must be ignored
    for (int i = 0; i < N; i++) begin
      wr(1, i, 0, 127);
      for (int j = 0; j < N; j++) wr(0, i, j, (i == j) ? 127 : -128);
    end
    wr_end();
    run = 1'b1;
    for (int s = 0; s < 3; s++) begin
      wait_sample(d);
      chk("R4 positive clamp sample", d, mm);
    end
    halt_at_boundary();

    // R3 R5: mixed weights with host backpressure pattern
    seed = 7;
    for (int i = 0; i < N; i++) begin
      seed = seed * 1103515245 + 12345;
      wr(1, i, 0, (seed >>> 16) % 40);
      for (int j = 0; j < N; j++) begin
        seed = seed * 1103515245 + 12345;
        wr(0, i, j, (seed >>> 16) % 128);
      end
    end
    wr_end();
    run = 1'b1;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      smp_ready = (c % 3) != 0;
    end
    smp_ready = 1'b1;

    // R2: writes while running are ignored
    for (int i = 0; i < N; i++) wr(1, i, 0, -128);
    for (int i = 0; i < N; i++) wr(0, i, (i + 1) % N, 127);
    wr_end();
    for (int s = 0; s < 4; s++) begin
      wait_sample(d);
      chk("R2 live write ignored", d, mm);
    end

    // R8: long stall keeps sample and engine still
    smp_ready = 1'b0;
    wait_sample(held);
    repeat (20) @(negedge clk);
    chk("R8 valid held in stall", {{(N-1){1'b0}}, smp_valid}, {{(N-1){1'b0}}, 1'b1});
    chk("R7 data stable in stall", smp_data, held);
    smp_ready = 1'b1;
    @(negedge clk);
    chk("R8 accept clears valid", {{(N-1){1'b0}}, smp_valid}, '0);

    // R9: freeze mid-sweep
    repeat (13) @(negedge clk);
    run = 1'b0;
    held = smp_data;
    repeat (15) @(negedge clk);
    chk("R9 state frozen", smp_data, held);
    chk("R9 no sample while halted", {{(N-1){1'b0}}, smp_valid}, '0);
    run = 1'b1;
    for (int s = 0; s < 3; s++) begin
      wait_sample(d);
      chk("R6 R9 resumed sweep", d, mm);
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule